// File: doc/BRIEF.md
# Dual Block-RAM Priority Arbiter

This block sits between several on-chip masters and two independent block RAMs. It decides, in every cycle and separately for each RAM, which master may use that RAM. The first RAM serves processor stores, instruction fetches, DMA loads and processor loads. The second RAM serves DMA stores and processor loads. Each RAM has its own fixed priority order.

Each master presents a request and a byte address. The block works out which RAM window the address falls in and picks the winner. The acknowledge to the winner is combinational, so it appears in the same cycle as the request. The winner's command is driven straight onto that RAM's port.

Read results come back through a pipeline of fixed depth. The pipeline carries the identity of the reader, so each returned word raises the valid strobe of the one master that asked for it.

Top module: `dual_bram_arbiter`

## Requirements
- R1: On RAM0, processor store beats instruction fetch, which beats DMA load, which beats processor load. Exactly one of the four is acknowledged whenever any of them targets RAM0.
- R2: On RAM1, a DMA store beats a processor load. Only those two masters are ever granted RAM1.
- R3: RAM0 owns byte addresses 0x3800_0000..0x3800_04FF and 0x3800_1000..0x3800_1FFF. RAM1 owns 0x3800_7000..0x3800_7FFF. A master that is not on a RAM's list is never granted that RAM.
- R4: An acknowledge is asserted in the same cycle as a request that wins. It is low in any cycle in which a higher-priority master holds that RAM.
- R5: A read accepted in cycle t raises its valid strobe in cycle t+LAT (LAT=10). Reads accepted in consecutive cycles give valid strobes in consecutive cycles, carrying the words in the order the reads were accepted.
- R6: Only the master that issued a read sees its valid strobe. Processor load data is taken from the RAM that served that load.
- R7: The two RAMs are arbitrated independently. One grant on each RAM may occur in the same cycle.
- R8: A request whose address lies outside every window is never acknowledged. It does not block lower-priority masters.
- R9: After reset, all read valid strobes are low, and no acknowledge is raised while no request is present.
- R10: A granted store drives enable, write-enable, address and data onto its RAM port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_req | input | 1 | Processor store request |
| cpu_wr_addr | input | AW | Processor store address |
| cpu_wr_data | input | DW | Processor store data |
| cpu_wr_ack | output | 1 | Processor store accepted |
| cpu_pf_req | input | 1 | Instruction fetch request |
| cpu_pf_addr | input | AW | Instruction fetch address |
| cpu_pf_ack | output | 1 | Instruction fetch accepted |
| dma_rd_req | input | 1 | DMA load request |
| dma_rd_addr | input | AW | DMA load address |
| dma_rd_ack | output | 1 | DMA load accepted |
| cpu_rd_req | input | 1 | Processor load request |
| cpu_rd_addr | input | AW | Processor load address |
| cpu_rd_ack | output | 1 | Processor load accepted (either RAM) |
| dma_wr_req | input | 1 | DMA store request |
| dma_wr_addr | input | AW | DMA store address |
| dma_wr_data | input | DW | DMA store data |
| dma_wr_ack | output | 1 | DMA store accepted |
| m0_en | output | 1 | RAM0 enable |
| m0_we | output | 1 | RAM0 write enable |
| m0_addr | output | MAW | RAM0 address (low byte-address bits) |
| m0_wdata | output | DW | RAM0 write data |
| m0_rdata | input | DW | RAM0 read data, one cycle after enable |
| m1_en | output | 1 | RAM1 enable |
| m1_we | output | 1 | RAM1 write enable |
| m1_addr | output | MAW | RAM1 address (low byte-address bits) |
| m1_wdata | output | DW | RAM1 write data |
| m1_rdata | input | DW | RAM1 read data, one cycle after enable |
| pf_rvalid | output | 1 | Fetch word valid |
| pf_rdata | output | DW | Fetch word |
| dma_rvalid | output | 1 | DMA load word valid |
| dma_rdata | output | DW | DMA load word |
| cpu_rvalid | output | 1 | Processor load word valid |
| cpu_rdata | output | DW | Processor load word |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, LAT=10, and the three address windows listed above. These values let the bench probe the edges of every window, and they make the ten-cycle return of a burst visible as consecutive strobes. The bench's RAM model keys on four word-address bits. That lets it track stores and loads on both RAMs, including a load on RAM1 that runs alongside a burst on RAM0.

// File: rtl/dual_bram_arbiter.sv
module dual_bram_arbiter #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int MAW = 13,
  parameter int LAT = 10,
  parameter logic [AW-1:0] W0A_LO = 'h3800_0000,
  parameter logic [AW-1:0] W0A_HI = 'h3800_04FF,
  parameter logic [AW-1:0] W0B_LO = 'h3800_1000,
  parameter logic [AW-1:0] W0B_HI = 'h3800_1FFF,
  parameter logic [AW-1:0] W1_LO  = 'h3800_7000,
  parameter logic [AW-1:0] W1_HI  = 'h3800_7FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_req,
  input  logic [AW-1:0] cpu_wr_addr,
  input  logic [DW-1:0] cpu_wr_data,
  output logic          cpu_wr_ack,
  input  logic          cpu_pf_req,
  input  logic [AW-1:0] cpu_pf_addr,
  output logic          cpu_pf_ack,
  input  logic          dma_rd_req,
  input  logic [AW-1:0] dma_rd_addr,
  output logic          dma_rd_ack,
  input  logic          cpu_rd_req,
  input  logic [AW-1:0] cpu_rd_addr,
  output logic          cpu_rd_ack,
  input  logic          dma_wr_req,
  input  logic [AW-1:0] dma_wr_addr,
  input  logic [DW-1:0] dma_wr_data,
  output logic          dma_wr_ack,
  output logic          m0_en,
  output logic          m0_we,
  output logic [MAW-1:0] m0_addr,
  output logic [DW-1:0] m0_wdata,
  input  logic [DW-1:0] m0_rdata,
  output logic          m1_en,
  output logic          m1_we,
  output logic [MAW-1:0] m1_addr,
  output logic [DW-1:0] m1_wdata,
  input  logic [DW-1:0] m1_rdata,
  output logic          pf_rvalid,
  output logic [DW-1:0] pf_rdata,
  output logic          dma_rvalid,
  output logic [DW-1:0] dma_rdata,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata
);
  localparam logic [1:0] ID_NONE = 2'd0, ID_PF = 2'd1, ID_DR = 2'd2, ID_CR = 2'd3;

  function automatic logic hit0(input logic [AW-1:0] a);
    return (a >= W0A_LO && a <= W0A_HI) || (a >= W0B_LO && a <= W0B_HI);
  endfunction
  function automatic logic hit1(input logic [AW-1:0] a);
    return a >= W1_LO && a <= W1_HI;
  endfunction

  logic cw0, pf0, dr0, cr0, cr1, dw1;
  assign cw0 = cpu_wr_req & hit0(cpu_wr_addr);
  assign pf0 = cpu_pf_req & hit0(cpu_pf_addr);
  assign dr0 = dma_rd_req & hit0(dma_rd_addr);
  assign cr0 = cpu_rd_req & hit0(cpu_rd_addr);
  assign cr1 = cpu_rd_req & hit1(cpu_rd_addr);
  assign dw1 = dma_wr_req & hit1(dma_wr_addr);

  logic g_pf, g_dr, g_cr0, g_cr1;
  assign g_pf  = pf0 & ~cw0;
  assign g_dr  = dr0 & ~cw0 & ~pf0;
  assign g_cr0 = cr0 & ~cw0 & ~pf0 & ~dr0;
  assign g_cr1 = cr1 & ~dw1;

  assign cpu_wr_ack = cw0;
  assign cpu_pf_ack = g_pf;
  assign dma_rd_ack = g_dr;
  assign cpu_rd_ack = g_cr0 | g_cr1;
  assign dma_wr_ack = dw1;

  assign m0_en    = cw0 | pf0 | dr0 | cr0;
  assign m0_we    = cw0;
  assign m0_wdata = cpu_wr_data;
  always_comb begin
    if (cw0)       m0_addr = cpu_wr_addr[MAW-1:0];
    else if (pf0)  m0_addr = cpu_pf_addr[MAW-1:0];
    else if (dr0)  m0_addr = dma_rd_addr[MAW-1:0];
    else           m0_addr = cpu_rd_addr[MAW-1:0];
  end

  assign m1_en    = dw1 | cr1;
  assign m1_we    = dw1;
  assign m1_wdata = dma_wr_data;
  assign m1_addr  = dw1 ? dma_wr_addr[MAW-1:0] : cpu_rd_addr[MAW-1:0];

  logic [1:0] tag0_in, tag1_in;
  assign tag0_in = g_pf ? ID_PF : g_dr ? ID_DR : g_cr0 ? ID_CR : ID_NONE;
  assign tag1_in = g_cr1 ? ID_CR : ID_NONE;

  logic [1:0]    t0 [LAT];
  logic [1:0]    t1 [LAT];
  logic [DW-1:0] d0 [LAT-1];
  logic [DW-1:0] d1 [LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        t0[i] <= ID_NONE;
        t1[i] <= ID_NONE;
      end
    end else begin
      t0[0] <= tag0_in;
      t1[0] <= tag1_in;
      for (int i = 1; i < LAT; i++) begin
        t0[i] <= t0[i-1];
        t1[i] <= t1[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    d0[0] <= m0_rdata;
    d1[0] <= m1_rdata;
    for (int i = 1; i < LAT-1; i++) begin
      d0[i] <= d0[i-1];
      d1[i] <= d1[i-1];
    end
  end

  logic [1:0] o0, o1;
  assign o0 = t0[LAT-1];
  assign o1 = t1[LAT-1];

  assign pf_rvalid  = o0 == ID_PF;
  assign dma_rvalid = o0 == ID_DR;
  assign cpu_rvalid = (o0 == ID_CR) | (o1 == ID_CR);
  assign pf_rdata   = d0[LAT-2];
  assign dma_rdata  = d0[LAT-2];
  assign cpu_rdata  = (o1 == ID_CR) ? d1[LAT-2] : d0[LAT-2];
endmodule

// File: rtl/dual_bram_arbiter_chk.sv
module dual_bram_arbiter_chk #(
  parameter int AW  = 32,
  parameter int LAT = 10,
  parameter logic [AW-1:0] W0A_LO = 'h3800_0000,
  parameter logic [AW-1:0] W0A_HI = 'h3800_04FF,
  parameter logic [AW-1:0] W0B_LO = 'h3800_1000,
  parameter logic [AW-1:0] W0B_HI = 'h3800_1FFF,
  parameter logic [AW-1:0] W1_LO  = 'h3800_7000,
  parameter logic [AW-1:0] W1_HI  = 'h3800_7FFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr_req,
  input logic [AW-1:0] cpu_wr_addr,
  input logic          cpu_wr_ack,
  input logic          cpu_pf_req,
  input logic          cpu_pf_ack,
  input logic          dma_rd_ack,
  input logic          cpu_rd_req,
  input logic [AW-1:0] cpu_rd_addr,
  input logic          cpu_rd_ack,
  input logic          dma_wr_req,
  input logic [AW-1:0] dma_wr_addr,
  input logic          dma_wr_ack,
  input logic          dma_rvalid
);
  logic in0_wr, in1_rd, in0_rd, in1_dw;
  assign in0_wr = (cpu_wr_addr >= W0A_LO && cpu_wr_addr <= W0A_HI) ||
                  (cpu_wr_addr >= W0B_LO && cpu_wr_addr <= W0B_HI);
  assign in0_rd = (cpu_rd_addr >= W0A_LO && cpu_rd_addr <= W0A_HI) ||
                  (cpu_rd_addr >= W0B_LO && cpu_rd_addr <= W0B_HI);
  assign in1_rd = cpu_rd_addr >= W1_LO && cpu_rd_addr <= W1_HI;
  assign in1_dw = dma_wr_addr >= W1_LO && dma_wr_addr <= W1_HI;

  logic [LAT-1:0] seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else        seen <= {seen[LAT-2:0], dma_rd_ack};

  AST_STORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_req && in0_wr) |-> (cpu_wr_ack && !cpu_pf_ack && !dma_rd_ack)); // R1
  AST_DMA_STORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr_req && in1_dw) |-> (dma_wr_ack && !(cpu_rd_ack && in1_rd))); // R2
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pf_ack |-> cpu_pf_req); // R4
  AST_DMA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rvalid == seen[LAT-1]); // R5
  AST_OUTSIDE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_req && !in0_rd && !in1_rd) |-> !cpu_rd_ack); // R8
endmodule

bind dual_bram_arbiter dual_bram_arbiter_chk #(
  .AW(AW), .LAT(LAT), .W0A_LO(W0A_LO), .W0A_HI(W0A_HI), .W0B_LO(W0B_LO),
  .W0B_HI(W0B_HI), .W1_LO(W1_LO), .W1_HI(W1_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_req(cpu_wr_req), .cpu_wr_addr(cpu_wr_addr),
  .cpu_wr_ack(cpu_wr_ack), .cpu_pf_req(cpu_pf_req), .cpu_pf_ack(cpu_pf_ack),
  .dma_rd_ack(dma_rd_ack), .cpu_rd_req(cpu_rd_req), .cpu_rd_addr(cpu_rd_addr),
  .cpu_rd_ack(cpu_rd_ack), .dma_wr_req(dma_wr_req), .dma_wr_addr(dma_wr_addr),
  .dma_wr_ack(dma_wr_ack), .dma_rvalid(dma_rvalid)
);

// File: tb/dual_bram_arbiter_test.sv
`timescale 1ns/1ps
module dual_bram_arbiter_test;
  localparam int LAT = 10;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cpu_wr_req = 0, cpu_pf_req = 0, dma_rd_req = 0, cpu_rd_req = 0, dma_wr_req = 0;
  logic [31:0] cpu_wr_addr = 0, cpu_pf_addr = 0, dma_rd_addr = 0, cpu_rd_addr = 0, dma_wr_addr = 0;
  logic [31:0] cpu_wr_data = 0, dma_wr_data = 0;
  logic cpu_wr_ack, cpu_pf_ack, dma_rd_ack, cpu_rd_ack, dma_wr_ack;
  logic m0_en, m0_we, m1_en, m1_we;
  logic [12:0] m0_addr, m1_addr;
  logic [31:0] m0_wdata, m1_wdata, m0_rdata, m1_rdata;
  logic pf_rvalid, dma_rvalid, cpu_rvalid;
  logic [31:0] pf_rdata, dma_rdata, cpu_rdata;

  dual_bram_arbiter uut (.*);

  logic [31:0] mem0 [16];
  logic [31:0] mem1 [16];
  initial for (int i = 0; i < 16; i++) begin
    mem0[i] = 32'hA000 + i;
    mem1[i] = 32'hB000 + i;
  end
  always @(posedge clk) begin
    if (m0_en && m0_we) mem0[m0_addr[5:2]] <= m0_wdata;
    if (m0_en && !m0_we) m0_rdata <= mem0[m0_addr[5:2]];
    if (m1_en && m1_we) mem1[m1_addr[5:2]] <= m1_wdata;
    if (m1_en && !m1_we) m1_rdata <= mem1[m1_addr[5:2]];
  end

  int errors = 0, checks = 0, cycles = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] sel_addr(input logic [1:0] s);
    case (s)
      2'd0: return 32'h3800_0010;
      2'd1: return 32'h3800_1020;
      2'd2: return 32'h3800_7040;
      default: return 32'h3800_2000;
    endcase
  endfunction

  // {req cw pf dr cr dw, sel cw pf dr cr dw, expected acks cw pf dr cr dw}
  localparam logic [19:0] VEC [12] = '{
    {5'b11111, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 5'b10001},
    {5'b01110, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 5'b01000},
    {5'b00110, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 5'b00100},
    {5'b00010, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 5'b00010},
    {5'b00011, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 5'b00001},
    {5'b00110, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 5'b00110},
    {5'b00010, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0, 5'b00000},
    {5'b11000, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0, 5'b01000},
    {5'b00110, 2'd0, 2'd0, 2'd3, 2'd1, 2'd0, 5'b00010},
    {5'b01000, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 5'b00000},
    {5'b00001, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 5'b00000},
    {5'b10011, 2'd1, 2'd0, 2'd0, 2'd2, 2'd2, 5'b10001}
  };

  task automatic idle();
    {cpu_wr_req, cpu_pf_req, dma_rd_req, cpu_rd_req, dma_wr_req} = '0;
  endtask

  task automatic probe_rd(input logic [31:0] a, input logic exp);
    @(negedge clk);
    idle(); cpu_rd_req = 1; cpu_rd_addr = a;
    #1 chk("R3 window edge", cpu_rd_ack, exp);
  endtask

  logic [2:0] sv_d, sv_c, sv_p;
  logic [31:0] sd [3];
  logic [31:0] sc;

  initial begin
    // R9: reset state
    #1 chk("R9 valid low in reset", {pf_rvalid, dma_rvalid, cpu_rvalid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 no ack idle", {cpu_wr_ack, cpu_pf_ack, dma_rd_ack, cpu_rd_ack, dma_wr_ack}, 0);
    chk("R9 valid low after reset", {pf_rvalid, dma_rvalid, cpu_rvalid}, 0);

    // R1 R2 R4 R7 R8: priority table
    foreach (VEC[k]) begin
      @(negedge clk);
      {cpu_wr_req, cpu_pf_req, dma_rd_req, cpu_rd_req, dma_wr_req} = VEC[k][19:15];
      cpu_wr_addr = sel_addr(VEC[k][14:13]);
      cpu_pf_addr = sel_addr(VEC[k][12:11]);
      dma_rd_addr = sel_addr(VEC[k][10:9]);
      cpu_rd_addr = sel_addr(VEC[k][8:7]);
      dma_wr_addr = sel_addr(VEC[k][6:5]);
      #1 chk("R1 R2 R4 R7 R8 grant row",
             {cpu_wr_ack, cpu_pf_ack, dma_rd_ack, cpu_rd_ack, dma_wr_ack}, VEC[k][4:0]);
    end

    // R3: window boundaries
    probe_rd(32'h3800_04FF, 1);
    probe_rd(32'h3800_0500, 0);
    probe_rd(32'h3800_0FFF, 0);
    probe_rd(32'h3800_1FFF, 1);
    probe_rd(32'h3800_6FFF, 0);
    probe_rd(32'h3800_7FFF, 1);
    probe_rd(32'h3800_8000, 0);
    @(negedge clk); idle();
    repeat (LAT + 2) @(negedge clk);

    // R5 R6 R7: DMA burst on RAM0 with a concurrent processor load on RAM1
    for (int i = 0; i < 3; i++) begin
      dma_rd_req = 1; dma_rd_addr = 32'h3800_0004 + 32'(i * 4);
      cpu_rd_req = (i == 0); cpu_rd_addr = 32'h3800_7010;
      #1 chk("R7 both RAMs granted", {dma_rd_ack, cpu_rd_ack}, (i == 0) ? 2'b11 : 2'b10);
      @(negedge clk);
    end
    idle();
    sv_d = 0; sv_c = 0; sv_p = 0;
    for (int n = 3; n <= 13; n++) begin
      if (n >= 10 && n <= 12) begin
        sv_d[n-10] = dma_rvalid; sd[n-10] = dma_rdata; sv_p[n-10] = pf_rvalid;
      end else begin
        chk("R5 no valid outside window", {dma_rvalid, cpu_rvalid, pf_rvalid}, 0);
      end
      if (n == 10) begin sv_c[0] = cpu_rvalid; sc = cpu_rdata; end
      if (n == 11) sv_c[1] = cpu_rvalid;
      @(negedge clk);
    end
    chk("R5 back-to-back valid", sv_d, 3'b111);
    chk("R5 burst word 0", sd[0], 32'hA001);
    chk("R5 burst word 1", sd[1], 32'hA002);
    chk("R5 burst word 2", sd[2], 32'hA003);
    chk("R6 fetch strobe untouched", sv_p, 0);
    chk("R6 processor strobe once", sv_c[1:0], 2'b01);
    chk("R6 processor data from RAM1", sc, 32'hB004);

    // R10: store drives RAM0 port in same cycle, read back
    cpu_wr_req = 1; cpu_wr_addr = 32'h3800_0008; cpu_wr_data = 32'hCAFE_0002;
    #1 chk("R10 store port", {m0_en, m0_we, 19'(m0_addr), m0_wdata},
           {1'b1, 1'b1, 19'h0008, 32'hCAFE_0002});
    @(negedge clk); idle();
    cpu_rd_req = 1; cpu_rd_addr = 32'h3800_0008;
    @(negedge clk); idle();
    repeat (LAT - 2) @(negedge clk);
    chk("R5 one cycle early", cpu_rvalid, 0);
    @(negedge clk);
    chk("R10 stored word returned", {cpu_rvalid, cpu_rdata}, {1'b1, 32'hCAFE_0002});

    // R4: fetch steals one cycle from a DMA burst
    dma_rd_req = 1; dma_rd_addr = 32'h3800_0004;
    #1 chk("R4 DMA ack idle arbiter", dma_rd_ack, 1);
    @(negedge clk);
    cpu_pf_req = 1; cpu_pf_addr = 32'h3800_1000;
    #1 chk("R4 DMA ack drops", {dma_rd_ack, cpu_pf_ack}, 2'b01);
    @(negedge clk); cpu_pf_req = 0;
    #1 chk("R4 DMA ack returns", dma_rd_ack, 1);
    @(negedge clk); idle();
    repeat (LAT + 2) @(negedge clk);
    finish_run();
  end
endmodule